// File: doc/BRIEF.md
# Programmable CRC / Pseudo-Random Shift Register Engine

This block is an 8-bit (by default) linear feedback shift register with a feedback polynomial that software sets. Software configures it through a small register port. In CRC mode the engine takes one serial data bit on every enabled clock and folds it into the running remainder. In pseudo-random mode it ignores the data pin and runs on its own feedback. The most significant bit of the shift register is presented on a serial output on every clock.

Three storage elements are involved. The polynomial register can only be written. The seed/residue register can be both read and written. The shift register state cannot be accessed directly. Software preloads the state by writing the seed while the engine is stopped. After a run, it recovers the remainder with a dummy read of the state address, which copies the state into the seed/residue register, and then reads that register. While the engine runs, a compare unit drives an auxiliary output. This output reports a relation, selected by mode pins, between the live state and the seed/residue value.

Top module: `lfsr_crc_engine`

## Requirements
- R1: After reset the polynomial, seed/residue and state are all zero, so serial_o is 0, aux_o is 0 and a read of the seed/residue address returns 00h.
- R2: Register addresses are 0 = state, 1 = polynomial, 2 = seed/residue, 3 = unused. A polynomial write takes effect only while enable_i is low. Polynomial writes while enabled are ignored. Reads of addresses 1 and 3 return 00h.
- R3: A seed/residue write while disabled loads the same value into the state on that clock edge.
- R4: A seed/residue write while enabled updates only the seed/residue register. The state continues its normal shift, and the new value becomes the compare operand from the next cycle.
- R5: A read of address 0 while disabled returns 00h. On that edge it copies the state into the seed/residue register. A read at the same time as any write performs the write only.
- R6: A read of address 0 while enabled returns 00h and leaves the seed/residue register unchanged.
- R7: On each enabled clock, the feedback bit is the state MSB XOR data_i. The next state is the state shifted left by one with a 0 entering bit 0, XORed with the polynomial when the feedback bit is 1, so polynomial bit n is tap n.
- R8: With prs_mode_i high, data_i has no effect and the feedback bit is the state MSB alone.
- R9: While enabled, aux_o reports the comparison selected by cmp_mode_i: 0 gives state == seed, 1 gives state <= seed, 2 gives state < seed, 3 gives state != seed (unsigned). While disabled, aux_o is 0.
- R10: serial_o always equals the state MSB.
- R11: While disabled, the state changes only through a seed/residue write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run the shift register |
| prs_mode_i | input | 1 | 1 = pseudo-random mode, 0 = CRC mode |
| data_i | input | 1 | Serial data bit for CRC mode |
| cmp_mode_i | input | 2 | Compare type for aux_o |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data (combinational) |
| serial_o | output | 1 | State MSB / pseudo-random bit |
| aux_o | output | 1 | Compare result |

## Verification
The assertions assume a register access carries at most one meaningful operation per cycle. When the bench issues a read, it never issues a write in the same cycle. They also assume the strobes are never unknown after reset, and the bench drives every input with a defined value on each falling edge. The random stimulus toggles enable, mode and compare type freely and mixes writes and reads over all four addresses. It therefore covers polynomial writes that must be dropped, seed writes on both sides of the enable and residue transfers. Directed passages force equality for the compare and a full CRC run with residue read-back.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;

   typedef enum logic [1:0] {
      CMP_EQ = 2'd0,
      CMP_LE = 2'd1,
      CMP_LT = 2'd2,
      CMP_NE = 2'd3
   } cmp_kind_e;

   typedef enum logic [1:0] {
      ADDR_STATE = 2'd0,
      ADDR_POLY  = 2'd1,
      ADDR_SEED  = 2'd2,
      ADDR_RSVD  = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/lfsr_crc_core.sv
module lfsr_crc_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             prs_mode_i,
   input  logic             data_i,
   input  logic [WIDTH-1:0] poly_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   output logic [WIDTH-1:0] state_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] nxt;
   logic             fb;

   if (WIDTH < 2) begin : g_bad_width
      $error("lfsr_crc_core: WIDTH must be at least 2");
   end

   assign fb = state_q[MSB] ^ (data_i & ~prs_mode_i);

   for (genvar g = 0; g < WIDTH; g++) begin : g_tap
      if (g == 0) begin : g_lsb
         assign nxt[g] = fb & poly_i[g];
      end else begin : g_upper
         assign nxt[g] = state_q[g-1] ^ (fb & poly_i[g]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= '0;
      end else if (load_i) begin
         state_q <= load_val_i;
      end else if (enable_i) begin
         state_q <= nxt;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/lfsr_crc_regs.sv
module lfsr_crc_regs
   import lfsr_crc_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [1:0]       addr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] state_i,
   output logic [WIDTH-1:0] poly_o,
   output logic [WIDTH-1:0] seed_o,
   output logic             load_o,
   output logic [WIDTH-1:0] load_val_o,
   output logic [WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] poly_q;
   logic [WIDTH-1:0] seed_q;
   logic             seed_wr;
   logic             poly_wr;
   logic             residue_grab;

   assign seed_wr      = wr_i && (addr_i == ADDR_SEED);
   assign poly_wr      = wr_i && !enable_i && (addr_i == ADDR_POLY);
   assign residue_grab = rd_i && !wr_i && !enable_i && (addr_i == ADDR_STATE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         poly_q <= '0;
      end else if (poly_wr) begin
         poly_q <= wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seed_q <= '0;
      end else if (seed_wr) begin
         seed_q <= wdata_i;
      end else if (residue_grab) begin
         seed_q <= state_i;
      end
   end

   assign load_o     = seed_wr && !enable_i;
   assign load_val_o = wdata_i;
   assign rdata_o    = (rd_i && addr_i == ADDR_SEED) ? seed_q : '0;
   assign poly_o     = poly_q;
   assign seed_o     = seed_q;

endmodule

// File: rtl/lfsr_crc_cmp.sv
module lfsr_crc_cmp
   import lfsr_crc_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             enable_i,
   input  logic [1:0]       mode_i,
   input  logic [WIDTH-1:0] state_i,
   input  logic [WIDTH-1:0] seed_i,
   output logic             aux_o
);

   logic eq, lt;

   assign eq = (state_i == seed_i);
   assign lt = (state_i < seed_i);

   always_comb begin
      aux_o = 1'b0;
      if (enable_i) begin
         unique case (cmp_kind_e'(mode_i))
            CMP_EQ:  aux_o = eq;
            CMP_LE:  aux_o = eq | lt;
            CMP_LT:  aux_o = lt;
            CMP_NE:  aux_o = ~eq;
            default: aux_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/lfsr_crc_engine.sv
module lfsr_crc_engine #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             prs_mode_i,
   input  logic             data_i,
   input  logic [1:0]       cmp_mode_i,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [1:0]       addr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             serial_o,
   output logic             aux_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("lfsr_crc_engine: WIDTH out of range 2..64");
   end

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] poly_q;
   logic [WIDTH-1:0] seed_q;
   logic             load;
   logic [WIDTH-1:0] load_val;

   lfsr_crc_regs #(.WIDTH(WIDTH)) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (enable_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .state_i    (state_q),
      .poly_o     (poly_q),
      .seed_o     (seed_q),
      .load_o     (load),
      .load_val_o (load_val),
      .rdata_o    (rdata_o)
   );

   lfsr_crc_core #(.WIDTH(WIDTH)) core_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (enable_i),
      .prs_mode_i (prs_mode_i),
      .data_i     (data_i),
      .poly_i     (poly_q),
      .load_i     (load),
      .load_val_i (load_val),
      .state_o    (state_q)
   );

   lfsr_crc_cmp #(.WIDTH(WIDTH)) cmp_i (
      .enable_i (enable_i),
      .mode_i   (cmp_mode_i),
      .state_i  (state_q),
      .seed_i   (seed_q),
      .aux_o    (aux_o)
   );

   assign serial_o = state_q[MSB];

endmodule

// File: rtl/lfsr_crc_engine_chk.sv
module lfsr_crc_engine_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             enable_i,
   input logic             wr_i,
   input logic             rd_i,
   input logic [1:0]       addr_i,
   input logic [WIDTH-1:0] wdata_i,
   input logic [WIDTH-1:0] rdata_o,
   input logic             serial_o,
   input logic             aux_o,
   input logic [WIDTH-1:0] state_q,
   input logic [WIDTH-1:0] poly_q,
   input logic [WIDTH-1:0] seed_q
);

   assert_poly_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && wr_i && addr_i == 2'd1) |=> $stable(poly_q));

   assert_seed_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && wr_i && addr_i == 2'd2) |=> (state_q == $past(wdata_i)));

   assert_seed_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && wr_i && addr_i == 2'd2) |=> (seed_q == $past(wdata_i)));

   assert_residue_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && rd_i && !wr_i && addr_i == 2'd0) |=> (seed_q == $past(state_q)));

   assert_state_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == 2'd0) |-> (rdata_o == '0));

   assert_enabled_read_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && rd_i && !wr_i) |=> $stable(seed_q));

   assert_aux_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |-> !aux_o);

   assert_serial_msb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      serial_o == state_q[WIDTH-1]);

   assert_state_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && !(wr_i && addr_i == 2'd2)) |=> $stable(state_q));

endmodule

bind lfsr_crc_engine lfsr_crc_engine_chk #(.WIDTH(WIDTH)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .enable_i (enable_i),
   .wr_i     (wr_i),
   .rd_i     (rd_i),
   .addr_i   (addr_i),
   .wdata_i  (wdata_i),
   .rdata_o  (rdata_o),
   .serial_o (serial_o),
   .aux_o    (aux_o),
   .state_q  (state_q),
   .poly_q   (poly_q),
   .seed_q   (seed_q)
);

// File: tb/lfsr_crc_engine_tb.sv
module lfsr_crc_engine_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0, prs = 1'b0, din = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [1:0]   cmode = 2'd0, addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         ser, aux;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_state = '0, m_poly = '0, m_seed = '0;

   always #2.5 clk = ~clk;

   lfsr_crc_engine #(.WIDTH(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .prs_mode_i(prs),
      .data_i(din), .cmp_mode_i(cmode), .wr_i(wr), .rd_i(rd),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .serial_o(ser), .aux_o(aux)
   );

   function automatic logic [W-1:0] lfsr_next(logic [W-1:0] s, logic [W-1:0] p, logic d);
      logic fb = s[W-1] ^ d;
      return {s[W-2:0], 1'b0} ^ (fb ? p : '0);
   endfunction

   function automatic logic cmp_ref(logic e, logic [1:0] m, logic [W-1:0] s, logic [W-1:0] k);
      if (!e) return 1'b0;
      case (m)
         2'd0: return s == k;
         2'd1: return s <= k;
         2'd2: return s < k;
         default: return s != k;
      endcase
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive on falling edge, check outputs, then advance the model.
   task automatic step(logic e, logic p, logic d, logic [1:0] cm,
                       logic w, logic r, logic [1:0] a, logic [W-1:0] wd, string rtag);
      logic [W-1:0] ns, nk, np;
      @(negedge clk);
      en = e; prs = p; din = d; cmode = cm; wr = w; rd = r; addr = a; wdata = wd;
      #1;
      check("R10 serial", {{(W-1){1'b0}}, ser}, {{(W-1){1'b0}}, m_state[W-1]});
      check("R9 aux", {{(W-1){1'b0}}, aux}, {{(W-1){1'b0}}, cmp_ref(e, cm, m_state, m_seed)});
      if (r) check(rtag, rdata, (a == 2'd2) ? m_seed : '0);
      ns = e ? lfsr_next(m_state, m_poly, p ? 1'b0 : d) : m_state;
      nk = m_seed;
      np = m_poly;
      if (w && a == 2'd1 && !e) np = wd;
      if (w && a == 2'd2) begin
         nk = wd;
         if (!e) ns = wd;
      end else if (r && !e && a == 2'd0) begin
         nk = m_state;
      end
      @(posedge clk);
      m_state = ns; m_seed = nk; m_poly = np;
   endtask

   task automatic idle(logic e, logic p, logic d);
      step(e, p, d, 2'd0, 1'b0, 1'b0, 2'd0, '0, "R7");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values seen at the ports
      check("R1 serial", {{(W-1){1'b0}}, ser}, '0);
      check("R1 aux", {{(W-1){1'b0}}, aux}, '0);
      rd = 1'b1; addr = 2'd2; #1;
      check("R1 seed", rdata, '0);
      rd = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      // R2: polynomial write while disabled; R3: seed mirrored into state
      step(0, 0, 0, 0, 1, 0, 2'd1, 8'h07, "R2");
      step(0, 0, 0, 0, 1, 0, 2'd2, 8'hA5, "R3");
      step(0, 0, 0, 0, 0, 1, 2'd1, '0, "R2 poly read zero");
      step(0, 0, 0, 0, 0, 1, 2'd3, '0, "R2 reserved read zero");
      // R5: dummy state read returns zero, then residue appears in seed
      step(0, 0, 0, 0, 0, 1, 2'd0, '0, "R5 state read");
      step(0, 0, 0, 0, 0, 1, 2'd2, '0, "R5 residue");
      // R7: CRC run over a byte
      v = 8'h3C;
      for (int i = W - 1; i >= 0; i--) idle(1, 0, v[i]);
      // R2: polynomial write while enabled must be ignored
      step(1, 0, 1, 0, 1, 0, 2'd1, 8'hFF, "R2");
      for (int i = 0; i < 6; i++) idle(1, 0, i[0]);
      // R11: disabled state holds across idle cycles
      for (int i = 0; i < 4; i++) idle(0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 2'd0, '0, "R5 state read");
      step(0, 0, 0, 0, 0, 1, 2'd2, '0, "R7 R11 residue");
      // R4 / R9: seed written with the predicted next state gives equality
      v = lfsr_next(lfsr_next(m_state, m_poly, 1'b0), m_poly, 1'b0);
      step(1, 1, 0, 0, 1, 0, 2'd2, v, "R4");
      step(1, 1, 1, 0, 0, 1, 2'd0, '0, "R6 enabled state read");
      step(1, 1, 0, 0, 0, 1, 2'd2, '0, "R6 seed untouched");
      // R8: pseudo-random mode with random data
      for (int i = 0; i < 40; i++) idle(1, 1, 1'($urandom));
      // Random mix
      for (int i = 0; i < 4000; i++) begin
         logic [2:0] op = 3'($urandom);
         logic w = (op == 3'd0);
         logic r = (op == 3'd1) || (op == 3'd2);
         step(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
              2'($urandom), w, r, 2'($urandom), W'($urandom), "R4 R5 R6 read");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule